// File: doc/BRIEF.md
# Interrupt-Triggered Serial Register Read Sequencer

This block is a host-side serial master for a sensor that flags fresh samples with a data-ready interrupt. Each rising edge of that interrupt starts a pass over a list of register addresses. The list and its length are inputs to the block. The block issues one 16-bit read command per address and returns each register's contents on a parallel valid/address/data port.

The sensor answers a command in the frame after it. The sequencer therefore overlaps each command with the previous frame's answer. It discards the answer that arrives during the first frame and appends one trailing dummy frame to collect the last answer. A list of N addresses costs N+1 frames, and each result is tagged with the address sent one frame earlier.

The serial clock is divided from the system clock by a runtime divider. A fast system clock can therefore meet a 2 MHz, 1 MHz or 300 kHz serial-clock limit. Chip select frames every transfer, and a minimum idle time is kept between frames.

Top module: `spi_rdseq`

## Requirements
- R1: Bus timing is clock polarity 1 and phase 1. The serial clock idles high whenever chip select is high. Outgoing data changes on falling edges and stays stable while the clock is high. Incoming data is sampled on rising edges. Frames are sent MSB first, with exactly 16 rising clock edges per frame.
- R2: Each low and high phase of the serial clock lasts `div_i`+1 system clock cycles.
- R3: A read command frame has bit 15 clear, the register address in bits 14 to 8, and zeros in bits 7 to 0.
- R4: Only a rising edge of `drdy_i` starts a sequence. Holding the input high does not start further sequences.
- R5: A sequence over N addresses sends N command frames in list order, followed by one dummy frame of value 0x0000, for N+1 frames in total.
- R6: The word received in the first frame is discarded. The word received in frame k+1 is presented as result k, tagged with the address commanded in frame k, as a one-cycle `res_valid_o` pulse. Exactly N results appear, in list order.
- R7: Chip select falls while the clock is high and before the first falling clock edge. Between consecutive frames of a sequence, chip select stays high for at least two clock phases (2*(`div_i`+1) system cycles).
- R8: A rising edge of `drdy_i` during a sequence sets `overrun_o` and neither restarts nor lengthens the sequence. `overrun_o` holds until the next accepted start clears it.
- R9: The count and address list are captured when a sequence starts. Changing them while the sequence runs has no effect on its frames or results.
- R10: A count of zero makes the block ignore the interrupt: no frame is sent and `busy_o` stays low. A count above MAX_REGS (default 8) is treated as MAX_REGS.
- R11: In reset, `cs_no` and `sclk_o` are high, and `mosi_o`, `busy_o`, `overrun_o` and `res_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drdy_i | input | 1 | Data-ready interrupt from the sensor, asynchronous |
| div_i | input | DIV_W (8) | Serial clock half-period minus one, in system cycles |
| reg_count_i | input | CNT_W (4) | Number of addresses to read |
| addr_list_i | input | MAX_REGS*7 (56) | Address list; entry i occupies bits [7i+6:7i] |
| miso_i | input | 1 | Serial data from the sensor |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the sensor |
| busy_o | output | 1 | A sequence is in progress |
| overrun_o | output | 1 | Interrupt seen while busy; sticky until the next start |
| res_valid_o | output | 1 | Result strobe, one cycle |
| res_addr_o | output | 7 | Address the result belongs to |
| res_data_o | output | 16 | Register contents |

## Verification
The final frame's completion and a fresh interrupt edge can land in the same cycle. In that cycle the sequencer leaves its running state, and the edge must be classed either as an overrun or as a new start. The bench provokes this by sweeping the arrival of a second interrupt edge cycle by cycle across the tail of the last frame. It judges each case at the pins: either `overrun_o` is set and only the original N+1 frames went out, or `overrun_o` is clear and a complete second sequence followed. A lost edge, or an overrun that also restarts, fails the check.

// File: rtl/spi_rdseq_pkg.sv
package spi_rdseq_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 7;
  localparam int PAD_W   = FRAME_W - 1 - ADDR_W;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_SETUP,
    SH_LOW,
    SH_HIGH,
    SH_HOLD,
    SH_GAP1,
    SH_GAP2
  } sh_state_e;

  function automatic logic [FRAME_W-1:0] read_cmd(input logic [ADDR_W-1:0] a);
    return {1'b0, a, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/spi_rdseq_irq_edge.sv
module spi_rdseq_irq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], irq_i};
  end

  assign rise_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/spi_rdseq_shifter.sv
module spi_rdseq_shifter
  import spi_rdseq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] cmd_i,
  input  logic               miso_i,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  output logic               idle_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_o
);
  localparam int BIT_W = $clog2(FRAME_W + 1);

  sh_state_e          state_q;
  logic [DIV_W-1:0]   div_cnt_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] tx_q, rx_q;
  logic               sclk_q, cs_q, done_q;
  logic               tick;

  assign tick = (div_cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SH_IDLE;
      div_cnt_q <= '0;
      bit_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      sclk_q    <= 1'b1;
      cs_q      <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == SH_IDLE) begin
        div_cnt_q <= '0;
        if (start_i) begin
          tx_q    <= cmd_i;
          bit_q   <= '0;
          cs_q    <= 1'b0;
          state_q <= SH_SETUP;
        end
      end else begin
        div_cnt_q <= tick ? '0 : div_cnt_q + 1'b1;
        if (tick) begin
          unique case (state_q)
            SH_SETUP: begin
              sclk_q  <= 1'b0;
              state_q <= SH_LOW;
            end
            SH_LOW: begin
              sclk_q  <= 1'b1;
              rx_q    <= {rx_q[FRAME_W-2:0], miso_i};
              bit_q   <= bit_q + 1'b1;
              state_q <= SH_HIGH;
            end
            SH_HIGH: begin
              if (bit_q == BIT_W'(FRAME_W)) begin
                state_q <= SH_HOLD;
              end else begin
                sclk_q  <= 1'b0;
                tx_q    <= {tx_q[FRAME_W-2:0], 1'b0};
                state_q <= SH_LOW;
              end
            end
            SH_HOLD: begin
              cs_q    <= 1'b1;
              done_q  <= 1'b1;
              state_q <= SH_GAP1;
            end
            SH_GAP1: state_q <= SH_GAP2;
            SH_GAP2: state_q <= SH_IDLE;
            default: state_q <= SH_IDLE;
          endcase
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign cs_no  = cs_q;
  assign mosi_o = tx_q[FRAME_W-1];
  assign idle_o = (state_q == SH_IDLE);
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_rdseq_ctrl.sv
module spi_rdseq_ctrl
  import spi_rdseq_pkg::*;
#(
  parameter int MAX_REGS = 8,
  parameter int CNT_W    = 4,
  parameter int IDX_W    = 4,
  parameter int SEL_W    = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       irq_rise_i,
  input  logic [CNT_W-1:0]           reg_count_i,
  input  logic [MAX_REGS*ADDR_W-1:0] addr_list_i,
  input  logic                       sh_idle_i,
  input  logic                       sh_done_i,
  input  logic [FRAME_W-1:0]         sh_rx_i,
  output logic                       sh_start_o,
  output logic [FRAME_W-1:0]         sh_cmd_o,
  output logic                       busy_o,
  output logic                       overrun_o,
  output logic                       res_valid_o,
  output logic [ADDR_W-1:0]          res_addr_o,
  output logic [FRAME_W-1:0]         res_data_o
);
  logic [ADDR_W-1:0]  addr_q [MAX_REGS];
  logic [IDX_W-1:0]   n_q, tx_idx_q, rx_idx_q, count_eff;
  logic               run_q, in_flight_q, overrun_q, accept;
  logic               res_valid_q;
  logic [ADDR_W-1:0]  res_addr_q;
  logic [FRAME_W-1:0] res_data_q;
  logic [IDX_W-1:0]   prev_idx;

  assign count_eff = (32'(reg_count_i) > MAX_REGS) ? IDX_W'(MAX_REGS) : IDX_W'(reg_count_i);
  assign accept    = !run_q && irq_rise_i && (count_eff != '0);

  for (genvar g = 0; g < MAX_REGS; g++) begin : g_list
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     addr_q[g] <= '0;
      else if (accept) addr_q[g] <= addr_list_i[g*ADDR_W +: ADDR_W];
    end
  end

  // Frames 0..n-1 carry commands, frame n is the dummy.
  assign sh_start_o = run_q && !in_flight_q && sh_idle_i && (tx_idx_q <= n_q);
  assign sh_cmd_o   = (tx_idx_q < n_q) ? read_cmd(addr_q[tx_idx_q[SEL_W-1:0]]) : '0;
  assign prev_idx   = rx_idx_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      in_flight_q <= 1'b0;
      overrun_q   <= 1'b0;
      n_q         <= '0;
      tx_idx_q    <= '0;
      rx_idx_q    <= '0;
      res_valid_q <= 1'b0;
      res_addr_q  <= '0;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (accept) begin
        run_q       <= 1'b1;
        in_flight_q <= 1'b0;
        overrun_q   <= 1'b0;
        n_q         <= count_eff;
        tx_idx_q    <= '0;
        rx_idx_q    <= '0;
      end else if (run_q) begin
        if (irq_rise_i) overrun_q <= 1'b1;
        if (sh_start_o) begin
          in_flight_q <= 1'b1;
          tx_idx_q    <= tx_idx_q + 1'b1;
        end
        if (sh_done_i) begin
          in_flight_q <= 1'b0;
          rx_idx_q    <= rx_idx_q + 1'b1;
          if (rx_idx_q != '0) begin
            res_valid_q <= 1'b1;
            res_addr_q  <= addr_q[prev_idx[SEL_W-1:0]];
            res_data_q  <= sh_rx_i;
          end
          if (rx_idx_q == n_q) run_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o      = run_q;
  assign overrun_o   = overrun_q;
  assign res_valid_o = res_valid_q;
  assign res_addr_o  = res_addr_q;
  assign res_data_o  = res_data_q;
endmodule

// File: rtl/spi_rdseq.sv
module spi_rdseq
  import spi_rdseq_pkg::*;
#(
  parameter int MAX_REGS = 8,
  parameter int DIV_W    = 8,
  parameter int CNT_W    = $clog2(MAX_REGS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       drdy_i,
  input  logic [DIV_W-1:0]           div_i,
  input  logic [CNT_W-1:0]           reg_count_i,
  input  logic [MAX_REGS*ADDR_W-1:0] addr_list_i,
  input  logic                       miso_i,
  output logic                       sclk_o,
  output logic                       cs_no,
  output logic                       mosi_o,
  output logic                       busy_o,
  output logic                       overrun_o,
  output logic                       res_valid_o,
  output logic [ADDR_W-1:0]          res_addr_o,
  output logic [FRAME_W-1:0]         res_data_o
);
  localparam int IDX_W = $clog2(MAX_REGS + 2);
  localparam int SEL_W = $clog2(MAX_REGS);

  logic               irq_rise, sh_start, sh_idle, sh_done;
  logic [FRAME_W-1:0] sh_cmd, sh_rx;

  spi_rdseq_irq_edge u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (drdy_i),
    .rise_o (irq_rise)
  );

  spi_rdseq_ctrl #(
    .MAX_REGS (MAX_REGS),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W),
    .SEL_W    (SEL_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_rise_i  (irq_rise),
    .reg_count_i (reg_count_i),
    .addr_list_i (addr_list_i),
    .sh_idle_i   (sh_idle),
    .sh_done_i   (sh_done),
    .sh_rx_i     (sh_rx),
    .sh_start_o  (sh_start),
    .sh_cmd_o    (sh_cmd),
    .busy_o      (busy_o),
    .overrun_o   (overrun_o),
    .res_valid_o (res_valid_o),
    .res_addr_o  (res_addr_o),
    .res_data_o  (res_data_o)
  );

  spi_rdseq_shifter #(
    .DIV_W (DIV_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div_i),
    .start_i (sh_start),
    .cmd_i   (sh_cmd),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .cs_no   (cs_no),
    .mosi_o  (mosi_o),
    .idle_o  (sh_idle),
    .done_o  (sh_done),
    .rx_o    (sh_rx)
  );
endmodule

// File: rtl/spi_rdseq_sva.sv
module spi_rdseq_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic cs_no,
  input logic mosi_o,
  input logic busy_o,
  input logic overrun_o,
  input logic res_valid_o
);
  logic       sclk_d;
  logic [4:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b1;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (cs_no)                 rise_cnt <= '0;
      else if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  a_r1_idle_clock_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  a_r1_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_o && $past(sclk_o) && !$past(cs_no)) |-> $stable(mosi_o));

  a_r1_sixteen_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (rise_cnt == 5'd16));

  a_r7_select_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (!cs_no && !$past(cs_no)));

  a_r6_result_in_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(busy_o));

  a_r8_overrun_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(busy_o));
endmodule

bind spi_rdseq spi_rdseq_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sclk_o      (sclk_o),
  .cs_no       (cs_no),
  .mosi_o      (mosi_o),
  .busy_o      (busy_o),
  .overrun_o   (overrun_o),
  .res_valid_o (res_valid_o)
);

// File: tb/spi_rdseq_tb.sv
module spi_rdseq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drdy = 1'b0;
  logic [7:0]  div = 8'd0;
  logic [3:0]  cnt = 4'd0;
  logic [55:0] list = '0;
  logic        miso = 1'b0;
  logic        sclk_o, cs_no, mosi_o, busy_o, overrun_o, res_valid_o;
  logic [6:0]  res_addr_o;
  logic [15:0] res_data_o;

  always #2 clk = ~clk;

  spi_rdseq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .drdy_i(drdy), .div_i(div),
    .reg_count_i(cnt), .addr_list_i(list), .miso_i(miso),
    .sclk_o(sclk_o), .cs_no(cs_no), .mosi_o(mosi_o), .busy_o(busy_o),
    .overrun_o(overrun_o), .res_valid_o(res_valid_o),
    .res_addr_o(res_addr_o), .res_data_o(res_data_o)
  );

  // {count, div, eight address bytes, byte 0 lowest}
  localparam logic [75:0] VECS [4] = '{
    {4'd1, 8'd0, 64'h0000_0000_0000_000A},
    {4'd3, 8'd2, 64'h0000_0000_003E_0A04},
    {4'd8, 8'd1, 64'h100E_0C0A_0806_0402},
    {4'd2, 8'd4, 64'h0000_0000_0000_007F}
  };

  int n_chk = 0, n_err = 0;
  int frame_n = 0, res_n = 0, min_gap = 1000, hi_run = 0, lo_run = 0, last_low = 0;
  bit busy_seen = 0;
  logic [15:0] cmd_log [32];
  logic [6:0]  ra_log [32];
  logic [15:0] rd_log [32];
  logic [6:0]  exp_addr [8];

  function automatic logic [15:0] model(input logic [6:0] a);
    return {a, 1'b1, ~a[3:0], a[6:3]};
  endfunction

  // sensor model: answers the previous frame's read command
  logic [15:0] s_resp = '0, s_rx = '0;
  int          s_fall = 0;
  logic        s_prev_rd = 1'b0;
  logic [6:0]  s_prev_addr = '0;
  always @(negedge cs_no) begin
    s_fall = 0; s_rx = '0;
    s_resp = s_prev_rd ? model(s_prev_addr) : 16'hFFFF;
  end
  always @(negedge sclk_o) if (!cs_no) begin
    if (s_fall < 16) miso = s_resp[15 - s_fall];
    s_fall++;
  end
  always @(posedge sclk_o) if (!cs_no) s_rx = {s_rx[14:0], mosi_o};
  always @(posedge cs_no) begin
    if (frame_n < 32) cmd_log[frame_n] = s_rx;
    frame_n++;
    s_prev_rd = !s_rx[15];
    s_prev_addr = s_rx[14:8];
  end

  always @(negedge clk) begin
    if (busy_o) busy_seen = 1;
    if (res_valid_o && res_n < 32) begin
      ra_log[res_n] = res_addr_o; rd_log[res_n] = res_data_o; res_n++;
    end
    if (cs_no) hi_run++;
    else if (hi_run != 0) begin
      if (frame_n > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
    if (!cs_no && !sclk_o) lo_run++;
    else if (lo_run != 0) begin last_low = lo_run; lo_run = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_list(input logic [63:0] bytes);
    for (int i = 0; i < 8; i++) begin
      list[i*7 +: 7] = bytes[i*8 +: 7];
      exp_addr[i]    = bytes[i*8 +: 7];
    end
  endtask

  task automatic clear_logs();
    res_n = 0; frame_n = 0; min_gap = 1000; busy_seen = 0;
  endtask

  task automatic pulse_drdy();
    @(negedge clk) drdy = 1'b1;
    repeat (3) @(negedge clk);
    drdy = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (8) @(negedge clk);
    for (int i = 0; i < 40000 && busy_o; i++) @(negedge clk);
    repeat (4 * (int'(div) + 1) + 8) @(negedge clk);
  endtask

  task automatic check_results(input int n, input string req);
    chk(res_n == n, req, res_n, n);
    for (int i = 0; i < n && i < res_n; i++) begin
      chk(ra_log[i] == exp_addr[i], req, ra_log[i], exp_addr[i]);
      chk(rd_log[i] == model(exp_addr[i]), req, rd_log[i], model(exp_addr[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R5 watchdog expired act=%0d exp=%0d", frame_n, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_no == 1'b1 && sclk_o == 1'b1, "R11 cs/sclk", {cs_no, sclk_o}, 3);
    chk({mosi_o, busy_o, overrun_o, res_valid_o} == 4'b0, "R11 outputs",
        {mosi_o, busy_o, overrun_o, res_valid_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clear_logs();

    // table walk: R1 R2 R3 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      cnt = VECS[v][75:72]; div = VECS[v][71:64]; set_list(VECS[v][63:0]);
      clear_logs();
      pulse_drdy();
      wait_idle();
      chk(frame_n == int'(cnt) + 1, "R5 frame count", frame_n, int'(cnt) + 1);
      for (int i = 0; i < int'(cnt); i++)
        chk(cmd_log[i] == {1'b0, exp_addr[i], 8'h00}, "R3 command",
            cmd_log[i], {1'b0, exp_addr[i], 8'h00});
      chk(cmd_log[cnt] == 16'h0000, "R5 dummy frame", cmd_log[cnt], 0);
      check_results(int'(cnt), "R6 result");
      chk(last_low == int'(div) + 1, "R2 half period", last_low, int'(div) + 1);
      chk(min_gap >= 2 * (int'(div) + 1), "R7 frame gap", min_gap, 2 * (int'(div) + 1));
      chk(overrun_o == 1'b0, "R8 no overrun", overrun_o, 0);
    end

    // R10 zero count ignored
    cnt = 4'd0; div = 8'd0; clear_logs();
    pulse_drdy();
    repeat (60) @(negedge clk);
    chk(!busy_seen && frame_n == 0, "R10 zero count", frame_n, 0);

    // R10 clamp above MAX_REGS
    cnt = 4'd15; set_list(64'h1E1C_1A18_1614_1211); clear_logs();
    pulse_drdy(); wait_idle();
    chk(frame_n == 9, "R10 clamp frames", frame_n, 9);
    check_results(8, "R10 clamp results");

    // R9 inputs latched at start
    cnt = 4'd3; div = 8'd1; set_list(64'h0000_0000_0021_2223); clear_logs();
    pulse_drdy();
    repeat (30) @(negedge clk);
    list = '1; cnt = 4'd5;
    wait_idle();
    cnt = 4'd3; set_list(64'h0000_0000_0021_2223);
    chk(frame_n == 4, "R9 frames", frame_n, 4);
    check_results(3, "R9 results");

    // R8 interrupt mid-sequence
    clear_logs();
    pulse_drdy();
    repeat (60) @(negedge clk);
    pulse_drdy();
    wait_idle();
    chk(overrun_o == 1'b1, "R8 overrun set", overrun_o, 1);
    chk(frame_n == 4, "R8 no restart", frame_n, 4);
    check_results(3, "R8 results");
    clear_logs();
    pulse_drdy(); wait_idle();
    chk(overrun_o == 1'b0, "R8 overrun cleared", overrun_o, 0);

    // R4 level held high starts one sequence only
    clear_logs();
    @(negedge clk) drdy = 1'b1;
    wait_idle();
    repeat (300) @(negedge clk);
    drdy = 1'b0;
    repeat (50) @(negedge clk);
    chk(frame_n == 4, "R4 level hold", frame_n, 4);

    // R8 edge swept across the end of the last frame
    cnt = 4'd1; div = 8'd3; set_list(64'h0000_0000_0000_0005);
    for (int k = 0; k < 8; k++) begin
      clear_logs();
      pulse_drdy();
      while (frame_n < 1) @(negedge clk);
      while (cs_no) @(negedge clk);
      while (s_fall < 16) @(negedge clk);
      while (!sclk_o) @(negedge clk);
      repeat (k) @(negedge clk);
      drdy = 1'b1;
      repeat (3) @(negedge clk);
      drdy = 1'b0;
      wait_idle();
      chk((overrun_o && frame_n == 2) || (!overrun_o && frame_n == 4),
          "R8 end-of-sequence race", {overrun_o, 8'(frame_n)}, 2);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule